// File: doc/BRIEF.md
# Real-Time Clock Seconds Stage with Host Hold

This block keeps the seconds digits of a real-time clock in BCD and advances them from a slow tick strobe. The strobe stands for a 32.768 kHz time base. A prescaler counts the strobes and produces one carry each second. Every change to the seconds value is made inside a timed update window, and a busy flag stays high for the whole window.

A host reaches the block through a small register port: address 0 holds the seconds value and address 1 holds control and status. The host can freeze the counter for a coherent read-modify-write by clearing a hold bit. While the counter is held, one incoming carry is remembered. It is applied as a single increment when the hold is lifted. Pulling the chip-enable input low lifts the hold by force. The host can also ask for rounding to the nearest minute. Values below thirty go to zero. Values of thirty and above go to zero and also emit a minute carry. The minute carry is a one-cycle output that drives the next stage up.

Top module: `rtc_sec_core`

## Requirements
- R1: The seconds value is BCD in the range 00..59. Every TICKS_PER_SEC tick strobes, one increment is made. An increment from 59 gives 00 and raises `min_carry` for exactly one clock cycle.
- R2: An increment runs in a window in which busy (control bit 2) is 1 for exactly INC_TICKS tick strobes. The new value and any minute carry appear when the window ends.
- R3: While the hold bit (control bit 0) is 0, no increment window starts and busy stays 0. The seconds value stays fixed, and the pending flag (control bit 3) reports that a carry is waiting.
- R4: When the hold bit is written back to 1, exactly one increment is applied, however many carries arrived during the hold.
- R5: While `ce` is 0, the hold bit is forced to 1 and every register write is ignored.
- R6: Writing 1 to the adjust bit (control bit 1) starts a window in which busy is 1 for exactly ADJ_TICKS tick strobes. At the end of that window, seconds 00..29 become 00 with no minute carry, and 30..59 become 00 with a minute carry. The adjust bit reads 1 until the window ends and 0 after it.
- R7: A register write made while busy is 1 is ignored. This applies to both the seconds register and the control register.
- R8: A write to the seconds register is ignored if either BCD digit is out of range, that is, if the ones digit is above 9 or the value is above 59.
- R9: After reset the seconds value reads 00, the control register reads 0x01 (hold released, no adjust, not busy, nothing pending), and `min_carry` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | One-cycle strobe per time-base tick |
| ce | input | 1 | Chip enable; low forces the hold off and blocks writes |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = seconds, 1 = control/status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register (combinational) |
| min_carry | output | 1 | One-cycle carry to the minutes stage |

## Verification
The assertions take for granted that `tick_en` is a single-cycle strobe. They also assume that TICKS_PER_SEC is larger than INC_TICKS, so that a new carry never lands inside an increment window. The bench meets both conditions: it uses a short second of eight ticks, and it issues every tick strobe itself with idle cycles in between. Before each increment case it releases any pending carry, so every measured window begins from an idle, clear state. It also holds the counter during adjust cases, so that a carry arriving inside the longer adjust window cannot chain a second update into the measurement.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;

    typedef struct packed {
        logic [3:0] tens;
        logic [3:0] ones;
    } bcd_sec_t;

    typedef struct packed {
        bcd_sec_t val;
        logic     carry;
    } sec_result_t;

    typedef enum logic {
        UPD_INC = 1'b0,
        UPD_ADJ = 1'b1
    } upd_kind_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

    typedef enum logic {
        ADDR_SEC  = 1'b0,
        ADDR_CTRL = 1'b1
    } reg_addr_t;

    localparam int CTRL_HOLDN_BIT = 0;
    localparam int CTRL_ADJ_BIT   = 1;
    localparam int CTRL_BUSY_BIT  = 2;
    localparam int CTRL_PEND_BIT  = 3;

    function automatic logic bcd_valid(input bcd_sec_t v);
        return (v.ones <= 4'd9) && (v.tens <= 4'd5);
    endfunction

    function automatic sec_result_t bcd_step(input bcd_sec_t v);
        sec_result_t r;
        r.carry = 1'b0;
        r.val   = v;
        if (v.ones == 4'd9) begin
            r.val.ones = 4'd0;
            if (v.tens == 4'd5) begin
                r.val.tens = 4'd0;
                r.carry    = 1'b1;
            end else begin
                r.val.tens = v.tens + 4'd1;
            end
        end else begin
            r.val.ones = v.ones + 4'd1;
        end
        return r;
    endfunction

    function automatic sec_result_t bcd_round(input bcd_sec_t v);
        sec_result_t r;
        r.val   = '0;
        r.carry = (v.tens >= 4'd3);
        return r;
    endfunction

endpackage

// File: rtl/rtc_sec_prescale.sv
module rtc_sec_prescale #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    output logic sec_pulse
);
    generate
        if (TICKS_PER_SEC <= 1) begin : g_direct
            assign sec_pulse = tick_en;
        end else begin : g_count
            localparam int CW = $clog2(TICKS_PER_SEC);
            localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
            logic [CW-1:0] cnt_q;
            logic          at_last;

            assign at_last   = (cnt_q == LAST);
            assign sec_pulse = tick_en && at_last;

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q <= '0;
                end else if (tick_en) begin
                    cnt_q <= at_last ? '0 : cnt_q + CW'(1);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/rtc_sec_seqr.sv
module rtc_sec_seqr
    import rtc_sec_pkg::*;
#(
    parameter int INC_TICKS = 3,
    parameter int ADJ_TICKS = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick_en,
    input  logic      pend,
    input  logic      hold_n,
    input  logic      adj_req,
    output logic      busy,
    output logic      start_inc,
    output logic      done,
    output upd_kind_t done_kind
);
    localparam int MAXT = (INC_TICKS > ADJ_TICKS) ? INC_TICKS : ADJ_TICKS;
    localparam int CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] INC_LEN = CW'(INC_TICKS);
    localparam logic [CW-1:0] ADJ_LEN = CW'(ADJ_TICKS);

    seq_state_t    state_q;
    upd_kind_t     kind_q;
    logic [CW-1:0] left_q;
    logic          idle;
    logic          start_adj;

    assign idle      = (state_q == SEQ_IDLE);
    assign start_adj = idle && adj_req;
    assign start_inc = idle && !adj_req && pend && hold_n;
    assign busy      = (state_q == SEQ_RUN);
    assign done      = busy && tick_en && (left_q == CW'(1));
    assign done_kind = kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            kind_q  <= UPD_INC;
            left_q  <= '0;
        end else begin
            if (start_adj) begin
                state_q <= SEQ_RUN;
                kind_q  <= UPD_ADJ;
                left_q  <= ADJ_LEN;
            end else if (start_inc) begin
                state_q <= SEQ_RUN;
                kind_q  <= UPD_INC;
                left_q  <= INC_LEN;
            end else if (done) begin
                state_q <= SEQ_IDLE;
                left_q  <= '0;
            end else if (busy && tick_en) begin
                left_q <= left_q - CW'(1);
            end
        end
    end
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter
    import rtc_sec_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  bcd_sec_t  load_val,
    input  logic      done,
    input  upd_kind_t done_kind,
    output bcd_sec_t  sec,
    output logic      min_carry
);
    bcd_sec_t    sec_q;
    logic        carry_q;
    sec_result_t nxt;

    always_comb begin
        if (done_kind == UPD_ADJ) nxt = bcd_round(sec_q);
        else                      nxt = bcd_step(sec_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            carry_q <= 1'b0;
            if (done) begin
                sec_q   <= nxt.val;
                carry_q <= nxt.carry;
            end else if (load) begin
                sec_q <= load_val;
            end
        end
    end

    assign sec       = sec_q;
    assign min_carry = carry_q;
endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core
    import rtc_sec_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int INC_TICKS     = 3,
    parameter int ADJ_TICKS     = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       ce,
    input  logic       reg_we,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       min_carry
);
    logic      sec_pulse;
    logic      seq_busy;
    logic      start_inc;
    logic      upd_done;
    upd_kind_t upd_kind;
    logic      hold_n_q;
    logic      adj_q;
    logic      pend_q;
    logic      wr_ok;
    logic      sec_wr;
    logic      ctrl_wr;
    bcd_sec_t  wr_val;
    bcd_sec_t  sec_val;
    logic [7:0] sec_bits;
    reg_addr_t addr;

    assign addr    = reg_addr_t'(reg_addr);
    assign wr_val  = bcd_sec_t'(reg_wdata);
    assign wr_ok   = reg_we && ce && !seq_busy;
    assign sec_wr  = wr_ok && (addr == ADDR_SEC) && bcd_valid(wr_val);
    assign ctrl_wr = wr_ok && (addr == ADDR_CTRL);

    rtc_sec_prescale #(
        .TICKS_PER_SEC(TICKS_PER_SEC)
    ) u_pre (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .sec_pulse(sec_pulse)
    );

    rtc_sec_seqr #(
        .INC_TICKS(INC_TICKS),
        .ADJ_TICKS(ADJ_TICKS)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .pend     (pend_q),
        .hold_n   (hold_n_q),
        .adj_req  (adj_q),
        .busy     (seq_busy),
        .start_inc(start_inc),
        .done     (upd_done),
        .done_kind(upd_kind)
    );

    rtc_sec_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (sec_wr),
        .load_val (wr_val),
        .done     (upd_done),
        .done_kind(upd_kind),
        .sec      (sec_val),
        .min_carry(min_carry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_n_q <= 1'b1;
            adj_q    <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            if (!ce)          hold_n_q <= 1'b1;
            else if (ctrl_wr) hold_n_q <= reg_wdata[CTRL_HOLDN_BIT];

            if (upd_done && upd_kind == UPD_ADJ)        adj_q <= 1'b0;
            else if (ctrl_wr && reg_wdata[CTRL_ADJ_BIT]) adj_q <= 1'b1;

            pend_q <= sec_pulse || (pend_q && !start_inc);
        end
    end

    assign sec_bits = sec_val;

    always_comb begin
        reg_rdata = '0;
        if (addr == ADDR_SEC) begin
            reg_rdata = sec_bits;
        end else begin
            reg_rdata[CTRL_HOLDN_BIT] = hold_n_q;
            reg_rdata[CTRL_ADJ_BIT]   = adj_q;
            reg_rdata[CTRL_BUSY_BIT]  = seq_busy;
            reg_rdata[CTRL_PEND_BIT]  = pend_q;
        end
    end
endmodule

// File: rtl/rtc_sec_chk.sv
module rtc_sec_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick_en,
    input logic       ce,
    input logic       busy,
    input logic       hold_n,
    input logic       adj,
    input logic [7:0] sec,
    input logic       min_carry
);
    assert_sec_bcd_R1: assert property (@(posedge clk) disable iff (rst)
        (sec[3:0] <= 4'd9) && (sec[7:4] <= 4'd5));

    assert_carry_width_R1: assert property (@(posedge clk) disable iff (rst)
        min_carry |=> !min_carry);

    assert_busy_ends_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(tick_en));

    assert_carry_at_window_end_R2: assert property (@(posedge clk) disable iff (rst)
        min_carry |-> ($past(busy) && !busy));

    assert_hold_blocks_window_R3: assert property (@(posedge clk) disable iff (rst)
        (!hold_n && !busy && !adj) |=> !busy);

    assert_ce_forces_release_R5: assert property (@(posedge clk) disable iff (rst)
        !ce |=> hold_n);

    assert_adj_clears_at_end_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(adj) |-> $fell(busy));

    assert_sec_frozen_in_window_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && busy) |-> $stable(sec));
endmodule

bind rtc_sec_core rtc_sec_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .ce       (ce),
    .busy     (seq_busy),
    .hold_n   (hold_n_q),
    .adj      (adj_q),
    .sec      (sec_bits),
    .min_carry(min_carry)
);

// File: tb/rtc_sec_core_tb_top.sv
module rtc_sec_core_tb_top;
    localparam int TPS  = 8;
    localparam int NINC = 3;
    localparam int NADJ = 4;
    localparam logic [1:0] OP_INC = 2'd0, OP_ADJ = 2'd1, OP_BAD = 2'd2;
    localparam int NV = 12;
    // {op, preset, expected seconds, expected minute carry}
    localparam logic [18:0] VEC [NV] = '{
        {OP_INC, 8'h09, 8'h10, 1'b0},
        {OP_INC, 8'h45, 8'h46, 1'b0},
        {OP_INC, 8'h59, 8'h00, 1'b1},
        {OP_INC, 8'h19, 8'h20, 1'b0},
        {OP_ADJ, 8'h29, 8'h00, 1'b0},
        {OP_ADJ, 8'h30, 8'h00, 1'b1},
        {OP_ADJ, 8'h59, 8'h00, 1'b1},
        {OP_ADJ, 8'h00, 8'h00, 1'b0},
        {OP_ADJ, 8'h14, 8'h00, 1'b0},
        {OP_BAD, 8'h5A, 8'h21, 1'b0},
        {OP_BAD, 8'h60, 8'h21, 1'b0},
        {OP_BAD, 8'hA0, 8'h21, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       ce = 1'b1;
    logic       reg_we = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       min_carry;

    int checks = 0;
    int fails = 0;
    int carry_cnt = 0;

    always #2.5 clk = ~clk;

    rtc_sec_core #(
        .TICKS_PER_SEC(TPS),
        .INC_TICKS    (NINC),
        .ADJ_TICKS    (NADJ)
    ) dut_i (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .ce       (ce),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .min_carry(min_carry)
    );

    always @(negedge clk) if (min_carry) carry_cnt++;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic is_busy(output logic b);
        logic [7:0] d;
        rd(1'b1, d);
        b = d[2];
    endtask

    task automatic tick_until_busy(output int n);
        logic b;
        n = 0;
        is_busy(b);
        while (!b && n < 100) begin
            tick();
            n++;
            is_busy(b);
        end
    endtask

    task automatic run_until_idle(output int n);
        logic b;
        n = 0;
        is_busy(b);
        while (b && n < 100) begin
            tick();
            n++;
            is_busy(b);
        end
    endtask

    task automatic settle();
        int n;
        wr(1'b1, 8'h01);
        run_until_idle(n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int n, m;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: reset state
        rd(1'b0, d); check("R9 seconds", d, 8'h00);
        rd(1'b1, d); check("R9 control", d, 8'h01);
        check("R9 min_carry", {7'd0, min_carry}, 8'h00);

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            logic [7:0] pre, exp;
            logic       expc;
            {op, pre, exp, expc} = VEC[i];
            settle();
            if (op == OP_INC) begin
                wr(1'b0, pre);
                carry_cnt = 0;
                tick_until_busy(n);
                run_until_idle(m);
                check("R2 inc window ticks", 8'(m), 8'(NINC));
                rd(1'b0, d); check("R1 increment", d, exp);
                check("R1 minute carry", 8'(carry_cnt), {7'd0, expc});
            end else if (op == OP_ADJ) begin
                wr(1'b1, 8'h00);
                wr(1'b0, pre);
                carry_cnt = 0;
                wr(1'b1, 8'h02);
                run_until_idle(m);
                check("R6 adjust window ticks", 8'(m), 8'(NADJ));
                rd(1'b0, d); check("R6 rounded value", d, exp);
                check("R6 minute carry", 8'(carry_cnt), {7'd0, expc});
                rd(1'b1, d); check("R6 adjust bit cleared", {7'd0, d[1]}, 8'h00);
            end else begin
                wr(1'b0, 8'h21);
                wr(1'b0, pre);
                rd(1'b0, d); check("R8 invalid write ignored", d, exp);
            end
        end

        // R1: one increment per TICKS_PER_SEC ticks
        settle();
        tick_until_busy(n);
        run_until_idle(m);
        tick_until_busy(n);
        check("R1 ticks per second", 8'(m + n), 8'(TPS));
        run_until_idle(m);

        // R3/R4: hold defers a single increment
        settle();
        wr(1'b0, 8'h33);
        wr(1'b1, 8'h00);
        n = 0;
        for (int k = 0; k < 2 * TPS; k++) begin
            logic b;
            tick();
            is_busy(b);
            if (b) n++;
        end
        check("R3 busy stays low in hold", 8'(n), 8'h00);
        rd(1'b0, d); check("R3 seconds frozen", d, 8'h33);
        rd(1'b1, d); check("R3 pending flag", {7'd0, d[3]}, 8'h01);
        wr(1'b1, 8'h01);
        run_until_idle(m);
        check("R2 deferred window ticks", 8'(m), 8'(NINC));
        rd(1'b0, d); check("R4 single increment", d, 8'h34);
        rd(1'b1, d); check("R4 pending cleared", {7'd0, d[3]}, 8'h00);

        // R5: chip enable low releases hold and blocks writes
        wr(1'b1, 8'h00);
        rd(1'b1, d); check("R5 hold set", {7'd0, d[0]}, 8'h00);
        @(negedge clk); ce = 1'b0;
        repeat (2) @(negedge clk);
        rd(1'b1, d); check("R5 hold forced off", {7'd0, d[0]}, 8'h01);
        wr(1'b0, 8'h12);
        rd(1'b0, d); check("R5 write ignored with ce low", d, 8'h34);
        @(negedge clk); ce = 1'b1;
        settle();

        // R7: writes ignored during a window
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h40);
        carry_cnt = 0;
        wr(1'b1, 8'h02);
        rd(1'b1, d); check("R6 busy and adjust bits", d & 8'h06, 8'h06);
        wr(1'b0, 8'h17);
        wr(1'b1, 8'h01);
        rd(1'b1, d); check("R7 control write ignored", {7'd0, d[0]}, 8'h00);
        run_until_idle(m);
        check("R6 adjust ticks", 8'(m), 8'(NADJ));
        rd(1'b0, d); check("R7 seconds write ignored", d, 8'h00);
        check("R6 carry from 40", 8'(carry_cnt), 8'h01);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule